// File: doc/BRIEF.md
# Address-Data Join Write Sequencer

This block pairs an address and a data word that reach it on two independent valid-qualified inputs. The two may come in either order or in the same cycle. An operand that arrives before its partner is held in a register. The write request is raised combinationally in the cycle the second operand shows up, so the join adds no cycle of delay. The payload is a fixed combinational mix of the two values. The same mix is computed whether an operand comes from its holding register or straight from the input pins.

After each write the sequencer stays deaf to new operands for a programmable number of latency ticks. It then returns to collecting. A replay input preempts everything: the write that would have fired in that cycle is suppressed, and held operands and the latency count are thrown away. Collection restarts on the next cycle. Operand valids are only seen from the cycle after reset or replay onward.

Top module: `addr_data_join_wr`

## Requirements
- R1: When reset is released the block is collecting with `wr_valid` low and no operand held. A pair presented in the first cycles after reset fires normally.
- R2: With address and data arriving in separate cycles, in either order, `wr_valid` is high in the cycle the later one is valid and low in every other cycle.
- R3: When both valids are high in the same collecting cycle with nothing held, `wr_valid` is high in that cycle.
- R4: `wr_payload` is `{A, L}`, where A is the address in bits [ADDR_W+DATA_W-1:DATA_W] and bit i of L is `data[i] ^ addr[i % ADDR_W]`. A held operand keeps contributing its captured value after its valid pulse ends.
- R5: With a latency L > 0 taken at the write, the block ignores operand valids until L tick pulses have been seen. The tick in the write cycle does not count. Collection resumes in the cycle after the L-th tick, and valids in that tick's cycle are also ignored.
- R6: With latency 0 at the write, the block is collecting again in the very next cycle.
- R7: In a cycle with replay high, `wr_valid` is low. Held operands and any remaining latency count are discarded, and the block is collecting in the next cycle.
- R8: Operand valids in a cycle where replay or reset is high are ignored and are not captured.
- R9: Tick pulses while collecting have no effect on the length of the next latency wait.
- R10: If an operand is presented again before its partner arrives, the newer value replaces the held one.
- R11: The latency input is sampled only in the write cycle. Later changes do not alter a wait already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Address operand present this cycle |
| addr_in | input | ADDR_W | Address operand |
| data_valid | input | 1 | Data operand present this cycle |
| data_in | input | DATA_W | Data operand |
| latency | input | LAT_W | Tick count to wait after a write |
| tick | input | 1 | Latency tick strobe |
| replay | input | 1 | Strong abort and restart |
| wr_valid | output | 1 | Write request, one cycle |
| wr_payload | output | ADDR_W+DATA_W | Write payload |

## Verification
The hardest cases to reach are the ones where an operand valid coincides with a boundary: the replay cycle, the reset cycle, or the cycle of the final latency tick. In each of these the operand must be dropped silently. Such a drop only becomes visible later, when a lone partner arrives and must not fire. Each scenario therefore offers one operand exactly in the boundary cycle and its partner alone in the following cycle. The bench expects no write, then completes the pair and checks that the write happens only then. Tick counting is stressed the same way: ticks are sent while collecting and the latency input is changed during a wait, and the bench then measures exactly which cycle reopens collection.

// File: rtl/jw_pkg.sv
package jw_pkg;
  typedef enum logic [0:0] {
    ST_COLLECT = 1'b0,
    ST_WAIT    = 1'b1
  } jw_state_e;
endpackage

// File: rtl/jw_slot.sv
module jw_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         take,
  input  logic         consume,
  input  logic [W-1:0] din,
  output logic         eff_v,
  output logic [W-1:0] eff
);
  logic         held;
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst || clr || consume) begin
      held <= 1'b0;
      if (rst) q <= '0;
    end else if (take) begin
      held <= 1'b1;
      q    <= din;
    end
  end

  assign eff_v = held | take;
  assign eff   = take ? din : q;

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clr |=> !held);
  a_r4_value_persists: assert property (@(posedge clk) disable iff (rst)
    (held && !take && !clr && !consume) |=> (held && $stable(q)));
endmodule

// File: rtl/jw_lat_cnt.sv
module jw_lat_cnt #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  input  logic             in_wait,
  input  logic             tick,
  output logic             done
);
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_val == '0) ? '0 : load_val - LAT_W'(1);
    end else if (in_wait && tick && cnt != '0) begin
      cnt <= cnt - LAT_W'(1);
    end
  end

  assign done = in_wait && tick && (cnt == '0);

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !tick && !clr && !load) |=> $stable(cnt));
  a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
    (in_wait && tick && cnt != '0 && !clr && !load) |=> (cnt == $past(cnt) - LAT_W'(1)));
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!in_wait && !load && !clr) |=> $stable(cnt));
endmodule

// File: rtl/jw_mix.sv
module jw_mix #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]        a,
  input  logic [DATA_W-1:0]        d,
  output logic [ADDR_W+DATA_W-1:0] y
);
  logic [DATA_W-1:0] low;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign low[i] = d[i] ^ a[i % ADDR_W];
  end

  assign y = {a, low};
endmodule

// File: rtl/addr_data_join_wr.sv
module addr_data_join_wr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 8,
  localparam int PAY_W = ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LAT_W-1:0]  latency,
  input  logic              tick,
  input  logic              replay,
  output logic              wr_valid,
  output logic [PAY_W-1:0]  wr_payload
);
  import jw_pkg::*;

  jw_state_e         st;
  logic              live, fire, lat_done;
  logic              a_ok, d_ok;
  logic [ADDR_W-1:0] a_eff;
  logic [DATA_W-1:0] d_eff;

  assign live = !rst && !replay && (st == ST_COLLECT);
  assign fire = live && a_ok && d_ok;

  jw_slot #(.W(ADDR_W)) u_aslot (
    .clk(clk), .rst(rst), .clr(replay), .take(live && addr_valid),
    .consume(fire), .din(addr_in), .eff_v(a_ok), .eff(a_eff));

  jw_slot #(.W(DATA_W)) u_dslot (
    .clk(clk), .rst(rst), .clr(replay), .take(live && data_valid),
    .consume(fire), .din(data_in), .eff_v(d_ok), .eff(d_eff));

  jw_lat_cnt #(.LAT_W(LAT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(replay), .load(fire), .load_val(latency),
    .in_wait(st == ST_WAIT), .tick(tick), .done(lat_done));

  jw_mix #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mix (
    .a(a_eff), .d(d_eff), .y(wr_payload));

  always_ff @(posedge clk) begin
    if (rst || replay) begin
      st <= ST_COLLECT;
    end else if (fire && latency != '0) begin
      st <= ST_WAIT;
    end else if (st == ST_WAIT && lat_done) begin
      st <= ST_COLLECT;
    end
  end

  assign wr_valid = fire;

  a_r7_no_write_on_replay: assert property (@(posedge clk) disable iff (rst)
    replay |-> !wr_valid);
  a_r5_enter_wait: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && latency != '0) |=> (st == ST_WAIT || $past(replay)));
  a_r6_no_wait: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && latency == '0) |=> (st == ST_COLLECT));
  a_r5_quiet_in_wait: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> !wr_valid);
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    replay |=> (st == ST_COLLECT));
endmodule

// File: tb/sim_addr_data_join_wr.sv
module sim_addr_data_join_wr;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_valid = 1'b0, data_valid = 1'b0, tick = 1'b0, replay = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [LW-1:0] latency = '0;
  logic          wr_valid;
  logic [AW+DW-1:0] wr_payload;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  addr_data_join_wr #(.ADDR_W(AW), .DATA_W(DW), .LAT_W(LW)) u0 (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr_in(addr_in),
    .data_valid(data_valid), .data_in(data_in), .latency(latency),
    .tick(tick), .replay(replay), .wr_valid(wr_valid), .wr_payload(wr_payload));

  function automatic logic [AW+DW-1:0] mix(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] l;
    for (int i = 0; i < DW; i++) l[i] = d[i] ^ a[i % AW];
    return {a, l};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit av, input logic [AW-1:0] a, input bit dv,
                       input logic [DW-1:0] d, input bit tk, input bit rp);
    addr_valid = av; addr_in = a; data_valid = dv; data_in = d; tick = tk; replay = rp;
  endtask

  // sample 1 ns after the negedge where inputs were set, then advance one cycle
  task automatic look(input bit exp_v, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    #1;
    chk(wr_valid == exp_v, tag, 64'(wr_valid), 64'(exp_v));
    if (exp_v && wr_valid)
      chk(wr_payload == mix(a, d), {tag, " payload"}, 64'(wr_payload), 64'(mix(a, d)));
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    drive(1, 16'h1111, 0, 0, 0, 0);
    look(0, 0, 0, "R1 R8 no write in reset");
    rst = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    look(0, 0, 0, "R1 idle after reset");
    drive(0, 0, 1, 32'hCAFE0001, 0, 0);
    look(0, 0, 0, "R8 reset-cycle address dropped");
    drive(1, 16'h2222, 0, 0, 0, 0);
    look(1, 16'h2222, 32'hCAFE0001, "R1 first pair after reset");
  endtask

  task automatic t_orders;
    latency = 0;
    drive(1, 16'hA5A5, 0, 0, 0, 0);
    look(0, 0, 0, "R2 addr first wait");
    drive(0, 16'hFFFF, 0, 0, 0, 0);
    look(0, 0, 0, "R4 held no strobe");
    drive(0, 0, 1, 32'h12345678, 0, 0);
    look(1, 16'hA5A5, 32'h12345678, "R2 R4 addr then data");
    drive(0, 0, 0, 0, 0, 0);
    look(0, 0, 0, "R6 single pulse");
    drive(0, 0, 1, 32'h0F0F0F0F, 0, 0);
    look(0, 0, 0, "R2 data first wait");
    drive(1, 16'h0042, 0, 0, 0, 0);
    look(1, 16'h0042, 32'h0F0F0F0F, "R2 R6 data then addr");
    drive(1, 16'h7E57, 1, 32'hDEADBEEF, 0, 0);
    look(1, 16'h7E57, 32'hDEADBEEF, "R3 same cycle");
  endtask

  task automatic t_latency;
    latency = 3;
    drive(1, 16'h0101, 1, 32'h1, 1, 0);
    look(1, 16'h0101, 32'h1, "R5 write with L=3");
    latency = 0;
    drive(0, 0, 0, 0, 1, 0); look(0, 0, 0, "R5 tick1");
    drive(1, 16'h9999, 1, 32'h9, 0, 0); look(0, 0, 0, "R5 pair ignored in wait");
    drive(0, 0, 0, 0, 1, 0); look(0, 0, 0, "R11 tick2");
    drive(1, 16'h3333, 0, 0, 1, 0); look(0, 0, 0, "R5 R11 tick3 addr dropped");
    drive(0, 0, 1, 32'h44, 0, 0); look(0, 0, 0, "R5 lone data after wait");
    drive(1, 16'h5555, 0, 0, 0, 0); look(1, 16'h5555, 32'h44, "R5 resumes after 3 ticks");
  endtask

  task automatic t_replay;
    latency = 0;
    drive(1, 16'hBEEF, 0, 0, 0, 0); look(0, 0, 0, "R7 capture addr");
    drive(0, 0, 1, 32'h77, 0, 1);   look(0, 0, 0, "R7 no write in replay cycle");
    drive(0, 0, 1, 32'h88, 0, 0);   look(0, 0, 0, "R7 R8 addr discarded");
    drive(1, 16'h0C0C, 0, 0, 0, 0); look(1, 16'h0C0C, 32'h88, "R7 restart pair");
    latency = 5;
    drive(1, 16'h1, 1, 32'h2, 0, 0); look(1, 16'h1, 32'h2, "R7 write L=5");
    drive(0, 0, 0, 0, 1, 1);        look(0, 0, 0, "R7 replay in wait");
    latency = 0;
    drive(1, 16'h6, 1, 32'h7, 0, 0); look(1, 16'h6, 32'h7, "R7 wait discarded");
  endtask

  task automatic t_ticks_collecting;
    latency = 2;
    drive(1, 16'h00AA, 0, 0, 1, 0); look(0, 0, 0, "R9 tick while collecting");
    drive(0, 0, 0, 0, 1, 0);        look(0, 0, 0, "R9 tick while collecting 2");
    drive(0, 0, 1, 32'hBB, 0, 0);   look(1, 16'h00AA, 32'hBB, "R9 write L=2");
    latency = 0;
    drive(0, 0, 0, 0, 1, 0);        look(0, 0, 0, "R9 tick1");
    drive(1, 16'h1, 1, 32'h1, 0, 0); look(0, 0, 0, "R9 still waiting");
    drive(0, 0, 0, 0, 1, 0);        look(0, 0, 0, "R9 tick2");
    drive(1, 16'h2, 1, 32'h3, 0, 0); look(1, 16'h2, 32'h3, "R9 wait was 2 ticks");
  endtask

  task automatic t_overwrite;
    latency = 0;
    drive(1, 16'h1000, 0, 0, 0, 0); look(0, 0, 0, "R10 first addr");
    drive(1, 16'h2000, 0, 0, 0, 0); look(0, 0, 0, "R10 second addr");
    drive(0, 0, 1, 32'hABCD, 0, 0); look(1, 16'h2000, 32'hABCD, "R10 newer addr used");
    drive(0, 0, 1, 32'h1, 0, 0);    look(0, 0, 0, "R10 first data");
    drive(0, 0, 1, 32'h2, 0, 0);    look(0, 0, 0, "R10 second data");
    drive(1, 16'h3, 0, 0, 0, 0);    look(1, 16'h3, 32'h2, "R10 newer data used");
  endtask

  bit done = 1'b0;

  initial begin
    @(negedge clk);
    t_reset();
    t_orders();
    t_latency();
    t_replay();
    t_ticks_collecting();
    t_overwrite();
    drive(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule